// File: doc/BRIEF.md
# Overclock Watchdog With Safe Frequency Fallback

This block guards a programmable clock generator against a bad overclock setting. Once armed, it counts down an interval built from an 8-bit count value and a fixed unit of ticks. Software shows the system is still alive by issuing service strobes, and any configuration write counts as one. Each strobe restarts the interval.

If the interval runs out, the block enters an alarm state. In that state it replaces the active frequency selection with a stored 5-bit safe code, raises an alarm status bit and drives an active-low system reset pulse. The alarm stays in force until software clears the enable or the system reset is applied. The PLL and the dividers sit outside this block. They consume the effective frequency code that the block produces.

Top module: `overclock_guard`

## Requirements
- R1: While armed, expiry occurs on the tick that completes `wd_count_i` × UNIT_TICKS ticks counted from arming or from the last service strobe. The alarm is not asserted after one tick fewer.
- R2: With the default UNIT_TICKS of 10, a count of 29 gives a timeout of exactly 290 ticks.
- R3: While `wd_enable_i` is 0, ticks do not advance any timeout, `alarm_o` stays 0 and `freq_out_o` equals `freq_sel_i`.
- R4: `alarm_o` goes to 1 in the clock cycle after the expiry.
- R5: While `alarm_o` is 1, `freq_out_o` equals `safe_code_i`. Otherwise it equals `freq_sel_i`.
- R6: `wdt_rst_n_o` goes low in the cycle after the expiry and stays low until RST_TICKS further ticks have been seen. It returns high on the last of those ticks.
- R7: A `service_i` pulse while armed restarts the full interval, including any partly counted unit.
- R8: Once set, `alarm_o` persists through ticks and service strobes while enabled. It clears in the cycle after `wd_enable_i` goes to 0.
- R9: Asserting `sys_rst_n` low clears the alarm, drives `wdt_rst_n_o` high and restores pass-through of `freq_sel_i`.
- R10: A count value of 0 is treated as 1, so the timeout is UNIT_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Asynchronous active-low system reset |
| tick_i | input | 1 | One-cycle time-base strobe (millisecond scale) |
| wd_enable_i | input | 1 | 1 arms the watchdog, 0 disables it and clears alarm |
| wd_count_i | input | 8 | Timeout in units of UNIT_TICKS ticks |
| safe_code_i | input | 5 | Frequency code forced during alarm |
| freq_sel_i | input | 5 | Frequency code selected in normal operation |
| service_i | input | 1 | One-cycle service strobe (configuration write) |
| freq_out_o | output | 5 | Effective frequency code to the synthesiser |
| alarm_o | output | 1 | Status: 0 normal, 1 alarm |
| wdt_rst_n_o | output | 1 | Active-low system reset pulse on expiry |

## Verification
The assertions assume that `tick_i` and `service_i` are single-cycle strobes, that `wd_enable_i` does not rise in the same cycle as a tick, and that `wd_count_i` stays stable while the watchdog is armed. The bench drives every strobe from the falling clock edge for one cycle, with an idle cycle in between. It changes the count and the enable only between scenarios, when no tick is pending.

// File: rtl/ocg_pkg.sv
package ocg_pkg;
  localparam int FREQ_W = 5;
  localparam int CNT_W  = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_ALARM = 2'd2
  } guard_state_t;

  // count value to start from; zero is promoted to one unit
  function automatic logic [CNT_W-1:0] start_units(input logic [CNT_W-1:0] cnt);
    return (cnt == '0) ? CNT_W'(1) : cnt;
  endfunction
endpackage

// File: rtl/ocg_interval_timer.sv
module ocg_interval_timer
  import ocg_pkg::*;
#(
  parameter int UNIT_TICKS = 10
) (
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic             reload,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  output logic             done
);
  localparam int UW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [UW-1:0] UNIT_LAST = UW'(UNIT_TICKS - 1);

  logic [UW-1:0]    unit_q;
  logic [CNT_W-1:0] units_left_q;
  logic             unit_end;

  assign unit_end = run && tick && (unit_q == UNIT_LAST);
  assign done     = unit_end && (units_left_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      unit_q       <= '0;
      units_left_q <= '0;
    end else if (reload) begin
      unit_q       <= '0;
      units_left_q <= start_units(count);
    end else if (run && tick) begin
      if (unit_q == UNIT_LAST) begin
        unit_q <= '0;
        if (units_left_q != '0) units_left_q <= units_left_q - CNT_W'(1);
      end else begin
        unit_q <= unit_q + UW'(1);
      end
    end
  end
endmodule

// File: rtl/ocg_reset_stretch.sv
module ocg_reset_stretch #(
  parameter int RST_TICKS = 3
) (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic start,
  input  logic tick,
  output logic rst_n_out
);
  localparam int PW = $clog2(RST_TICKS + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)                  left_q <= '0;
    else if (start)                  left_q <= PW'(RST_TICKS);
    else if (tick && left_q != '0)   left_q <= left_q - PW'(1);
  end

  assign rst_n_out = (left_q == '0);
endmodule

// File: rtl/overclock_guard.sv
module overclock_guard
  import ocg_pkg::*;
#(
  parameter int UNIT_TICKS = 10,
  parameter int RST_TICKS  = 3
) (
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              tick_i,
  input  logic              wd_enable_i,
  input  logic [CNT_W-1:0]  wd_count_i,
  input  logic [FREQ_W-1:0] safe_code_i,
  input  logic [FREQ_W-1:0] freq_sel_i,
  input  logic              service_i,
  output logic [FREQ_W-1:0] freq_out_o,
  output logic              alarm_o,
  output logic              wdt_rst_n_o
);
  guard_state_t state_q, state_d;
  logic timer_reload, timer_run, timer_done;
  logic expire_evt;

  assign timer_run    = (state_q == ST_ARMED) && !service_i;
  assign timer_reload = (state_q != ST_ARMED) || service_i;
  assign expire_evt   = timer_done && wd_enable_i;

  ocg_interval_timer #(.UNIT_TICKS(UNIT_TICKS)) u_timer (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .reload    (timer_reload),
    .run       (timer_run),
    .tick      (tick_i),
    .count     (wd_count_i),
    .done      (timer_done)
  );

  ocg_reset_stretch #(.RST_TICKS(RST_TICKS)) u_stretch (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .start     (expire_evt),
    .tick      (tick_i),
    .rst_n_out (wdt_rst_n_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (wd_enable_i) state_d = ST_ARMED;
      ST_ARMED: if (!wd_enable_i) state_d = ST_IDLE;
                else if (expire_evt) state_d = ST_ALARM;
      ST_ALARM: if (!wd_enable_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  assign alarm_o    = (state_q == ST_ALARM);
  assign freq_out_o = alarm_o ? safe_code_i : freq_sel_i;
endmodule

// File: rtl/ocg_checker.sv
module ocg_checker
  import ocg_pkg::*;
(
  input logic              clk,
  input logic              sys_rst_n,
  input logic              wd_enable_i,
  input logic [FREQ_W-1:0] safe_code_i,
  input logic [FREQ_W-1:0] freq_sel_i,
  input logic [FREQ_W-1:0] freq_out_o,
  input logic              alarm_o,
  input logic              wdt_rst_n_o,
  input logic              expire_evt
);
  p_expire_alarm_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    expire_evt |=> alarm_o);

  p_safe_code_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    alarm_o |-> freq_out_o == safe_code_i);

  p_pass_through_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !alarm_o |-> freq_out_o == freq_sel_i);

  p_reset_pulse_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    expire_evt |=> !wdt_rst_n_o);

  p_alarm_holds_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (alarm_o && wd_enable_i) |=> alarm_o);

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !wd_enable_i |=> !alarm_o);

  p_no_expire_disabled_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !wd_enable_i |-> !expire_evt);
endmodule

bind overclock_guard ocg_checker u_chk (
  .clk         (clk),
  .sys_rst_n   (sys_rst_n),
  .wd_enable_i (wd_enable_i),
  .safe_code_i (safe_code_i),
  .freq_sel_i  (freq_sel_i),
  .freq_out_o  (freq_out_o),
  .alarm_o     (alarm_o),
  .wdt_rst_n_o (wdt_rst_n_o),
  .expire_evt  (expire_evt)
);

// File: tb/overclock_guard_test.sv
`timescale 1ns/1ps
module overclock_guard_test;
  localparam int UNIT = 10;
  localparam int RSTT = 3;

  logic clk = 1'b0;
  logic sys_rst_n = 1'b0;
  logic tick_i = 1'b0, wd_enable_i = 1'b0, service_i = 1'b0;
  logic [7:0] wd_count_i = 8'd3;
  logic [4:0] safe_code_i = 5'h00, freq_sel_i = 5'h0C;
  logic [4:0] freq_out_o;
  logic alarm_o, wdt_rst_n_o;
  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  overclock_guard #(.UNIT_TICKS(UNIT), .RST_TICKS(RSTT)) uut (
    .clk(clk), .sys_rst_n(sys_rst_n), .tick_i(tick_i), .wd_enable_i(wd_enable_i),
    .wd_count_i(wd_count_i), .safe_code_i(safe_code_i), .freq_sel_i(freq_sel_i),
    .service_i(service_i), .freq_out_o(freq_out_o), .alarm_o(alarm_o),
    .wdt_rst_n_o(wdt_rst_n_o));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic service();
    @(negedge clk) service_i = 1'b1;
    @(negedge clk) service_i = 1'b0;
  endtask

  task automatic arm(input int cnt);
    @(negedge clk) wd_enable_i = 1'b0; wd_count_i = 8'(cnt);
    @(negedge clk) wd_enable_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check("R9 alarm after reset", alarm_o, 0);
    check("R9 reset out high", wdt_rst_n_o, 1);
    check("R9 freq pass", freq_out_o, 5'h0C);
  endtask

  task automatic t_disabled();
    wd_count_i = 8'd1;
    ticks(3 * UNIT);
    check("R3 no alarm disabled", alarm_o, 0);
    check("R3 freq pass disabled", freq_out_o, 5'h0C);
  endtask

  task automatic t_timeout();
    safe_code_i = 5'h1B;
    arm(3);
    ticks(3 * UNIT - 1);
    check("R1 no alarm one tick early", alarm_o, 0);
    check("R1 rst high before expiry", wdt_rst_n_o, 1);
    ticks(1);
    check("R4 alarm on expiry", alarm_o, 1);
    check("R5 safe code forced", freq_out_o, 5'h1B);
    check("R6 rst low", wdt_rst_n_o, 0);
    ticks(RSTT - 1);
    check("R6 rst still low", wdt_rst_n_o, 0);
    ticks(1);
    check("R6 rst released", wdt_rst_n_o, 1);
    ticks(5); service(); ticks(2 * UNIT);
    check("R8 alarm persists", alarm_o, 1);
    check("R8 safe persists", freq_out_o, 5'h1B);
    @(negedge clk) wd_enable_i = 1'b0;
    @(negedge clk);
    check("R8 disable clears alarm", alarm_o, 0);
    check("R5 pass after clear", freq_out_o, 5'h0C);
  endtask

  task automatic t_service();
    arm(2);
    ticks(15);
    service();
    ticks(2 * UNIT - 1);
    check("R7 service restarts interval", alarm_o, 0);
    ticks(1);
    check("R7 expiry after full reload", alarm_o, 1);
  endtask

  task automatic t_default_290();
    arm(29);
    ticks(289);
    check("R2 no alarm at 289", alarm_o, 0);
    ticks(1);
    check("R2 alarm at 290", alarm_o, 1);
  endtask

  task automatic t_zero_count();
    arm(0);
    ticks(UNIT - 1);
    check("R10 zero count early", alarm_o, 0);
    ticks(1);
    check("R10 zero count expires", alarm_o, 1);
  endtask

  task automatic t_sys_reset();
    @(negedge clk) sys_rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears alarm", alarm_o, 0);
    check("R9 reset rst out high", wdt_rst_n_o, 1);
    check("R9 reset freq pass", freq_out_o, 5'h0C);
    sys_rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_disabled();
    t_timeout();
    t_service();
    t_default_290();
    t_zero_count();
    t_sys_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule